// File: doc/BRIEF.md
# Up/Down BCD Elapsed-Time Counter

This block keeps an elapsed time as six binary-coded decimal digits: two for hours, two for minutes and two for seconds. On each rising clock edge, a step-up pulse advances the time by one second and a step-down pulse moves it back by one second. Carries and borrows pass through every digit in a single cycle. The seconds and minutes fields count modulo 60. The hours field runs from 00 to 99 and does not wrap at 24 hours. The whole range is 0 to 359999 seconds.

The digit outputs come straight from the registers and can drive display decoders directly. A synchronous active-low reset returns the count to 00:00:00.

Top module: `tape_time_counter`

## Requirements
- R1: There are six 4-bit BCD outputs: hour tens, hour units, minute tens, minute units, second tens and second units. Each holds the value of its own decimal digit.
- R2: When rst_n is low at a rising edge, every digit becomes 0. Reset takes priority over step_up and step_down.
- R3: When both step_up and step_down are low at an edge, all six digits keep their values.
- R4: When step_up is high at an edge, the time increases by exactly one second. Units digits wrap from 9 to 0. Minute and second tens digits wrap from 5 to 0. Each wrap carries one into the next digit up.
- R5: When only step_down is high at an edge, the time decreases by exactly one second. A units digit at 0 becomes 9, and a minute or second tens digit at 0 becomes 5. Each such wrap borrows one from the next digit up.
- R6: When step_up and step_down are both high at an edge, the count behaves as a single increment.
- R7: An increment from 99:59:59 gives 00:00:00.
- R8: A decrement from 00:00:00 gives 99:59:59.
- R9: Hours continue past 23. An increment from 23:59:59 gives 24:00:00.
- R10: No digit ever holds a value above its own limit: 9 for units digits, 5 for minute and second tens, and 9 for hour tens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_up | input | 1 | Add one second on this edge |
| step_down | input | 1 | Subtract one second on this edge |
| hr_tens | output | 4 | Hours, tens digit |
| hr_units | output | 4 | Hours, units digit |
| min_tens | output | 4 | Minutes, tens digit |
| min_units | output | 4 | Minutes, units digit |
| sec_tens | output | 4 | Seconds, tens digit |
| sec_units | output | 4 | Seconds, units digit |

## Verification
The bench builds the block with its default hour-tens limit of 9, which gives the full 00 to 99 hour range. With that limit, both ends of the range can be reached in one step from reset: a single decrement from zero wraps to 99:59:59, and the next increment returns to zero.

A long run of single increments goes through the 00:59:59 and 09:59:59 boundaries and reaches 24:00:00. That run shows every carry chain at its longest and confirms that the hours do not wrap at 24. Each step is compared against a seconds-based model.

// File: rtl/tape_time_counter.sv
module tape_time_counter #(
  parameter int unsigned HR_TENS_TOP = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_up,
  input  logic       step_down,
  output logic [3:0] hr_tens,
  output logic [3:0] hr_units,
  output logic [3:0] min_tens,
  output logic [3:0] min_units,
  output logic [3:0] sec_tens,
  output logic [3:0] sec_units
);
  localparam int NDIG = 6;

  function automatic logic [3:0] top_of(int idx);
    case (idx)
      1, 3:    top_of = 4'd5;
      5:       top_of = HR_TENS_TOP[3:0];
      default: top_of = 4'd9;
    endcase
  endfunction

  localparam logic [23:0] ALL_TOP = {top_of(5), top_of(4), top_of(3),
                                     top_of(2), top_of(1), top_of(0)};

  logic [3:0] dig [NDIG];
  logic [NDIG-1:0] cy, bw;
  logic [23:0] flat;

  assign cy[0] = step_up;
  assign bw[0] = step_down & ~step_up;
  assign flat  = {dig[5], dig[4], dig[3], dig[2], dig[1], dig[0]};

  for (genvar gi = 0; gi < NDIG; gi++) begin : g_digit
    localparam logic [3:0] TOP = top_of(gi);

    if (gi < NDIG-1) begin : g_chain
      assign cy[gi+1] = cy[gi] & (dig[gi] == TOP);
      assign bw[gi+1] = bw[gi] & (dig[gi] == 4'd0);
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        dig[gi] <= 4'd0;
      else if (cy[gi])
        dig[gi] <= (dig[gi] == TOP) ? 4'd0 : dig[gi] + 4'd1;
      else if (bw[gi])
        dig[gi] <= (dig[gi] == 4'd0) ? TOP : dig[gi] - 4'd1;
    end

    a_r10_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
      dig[gi] <= TOP);
  end

  assign sec_units = dig[0];
  assign sec_tens  = dig[1];
  assign min_units = dig[2];
  assign min_tens  = dig[3];
  assign hr_units  = dig[4];
  assign hr_tens   = dig[5];

  a_r2_sync_clear: assert property (@(posedge clk)
    !rst_n |=> flat == 24'd0);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_up && !step_down) |=> $stable(flat));

  a_r7_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && flat == ALL_TOP) |=> flat == 24'd0);

  a_r8_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step_down && !step_up && flat == 24'd0) |=> flat == ALL_TOP);
endmodule

// File: tb/test_tape_time_counter.sv
module test_tape_time_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_up = 1'b0;
  logic step_down = 1'b0;
  logic [3:0] hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units;

  int n_chk = 0;
  int n_bad = 0;
  int model = 0;

  always #5 clk = ~clk;

  tape_time_counter i_tape_time_counter (
    .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_down(step_down),
    .hr_tens(hr_tens), .hr_units(hr_units), .min_tens(min_tens),
    .min_units(min_units), .sec_tens(sec_tens), .sec_units(sec_units));

  // op: 0 hold, 1 up, 2 down, 3 both; reps; expected seconds after the entry
  localparam logic [40:0] VEC [14] = '{
    {2'd2, 20'd1,     19'd359999},  // R8 wrap down from zero
    {2'd1, 20'd1,     19'd0},       // R7 wrap up to zero
    {2'd1, 20'd59,    19'd59},
    {2'd1, 20'd1,     19'd60},      // R4 second carry
    {2'd2, 20'd1,     19'd59},      // R5 second borrow
    {2'd1, 20'd3541,  19'd3600},
    {2'd2, 20'd1,     19'd3599},
    {2'd1, 20'd32400, 19'd35999},
    {2'd1, 20'd1,     19'd36000},   // 09:59:59 -> 10:00:00
    {2'd2, 20'd1,     19'd35999},
    {2'd3, 20'd5,     19'd36004},   // R6 both high
    {2'd0, 20'd10,    19'd36004},   // R3 hold
    {2'd1, 20'd50395, 19'd86399},
    {2'd1, 20'd1,     19'd86400}    // R9 23:59:59 -> 24:00:00
  };

  function automatic logic [23:0] to_digits(int s);
    int h, m, x;
    h = s / 3600; m = (s % 3600) / 60; x = s % 60;
    return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(x / 10), 4'(x % 10)};
  endfunction

  task automatic check(string req, int secs);
    logic [23:0] got, exp;
    got = {hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units};
    exp = to_digits(secs);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(logic [1:0] op);
    step_up = op[0];
    step_down = op[1];
    @(negedge clk);
    if (op[0]) model = (model + 1) % 360000;
    else if (op[1]) model = (model == 0) ? 359999 : model - 1;
    case (op)
      2'd0: check("R3", model);
      2'd1: check("R4", model);
      2'd2: check("R5", model);
      default: check("R6", model);
    endcase
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1 R2 reset state", 0);
    rst_n = 1'b1;
    foreach (VEC[k]) begin
      for (int r = 0; r < int'(VEC[k][38:19]); r++) step(VEC[k][40:39]);
      check("R9 table end", int'(VEC[k][18:0]));
    end
    // R2: reset wins over step_up
    step_up = 1'b1; rst_n = 1'b0;
    @(negedge clk);
    model = 0;
    check("R2", 0);
    rst_n = 1'b1; step_up = 1'b0;
    @(negedge clk);
    check("R3", 0);
    step(2'd2);
    check("R8", 359999);
    step(2'd1);
    check("R7", 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule